// File: doc/BRIEF.md
# Iterative Shift-Add Multiplier

This block multiplies two operands over several clock cycles, one multiplier bit per cycle, using a single adder. It supports two operand sizes: byte (8×8 giving 16 bits) and word (16×16 giving 32 bits). Each operation also picks either unsigned or two's-complement signed arithmetic. The host pulses `start` with the operands, the size bit and the signed bit. Some cycles later the block pulses `done`, and then the product is available as a high half and a low half, together with a carry flag and an overflow flag.

Inside, the running sum and the multiplier share one register pair. The pair rotates right through a single carry bit, so the sum grows into the space that the spent multiplier bits free up. For signed work, both operands are first turned into magnitudes, and a one-bit flag records the sign of the product. After the unsigned loop, the split product is negated if that flag is set. The flags report whether the high half carries information beyond the low half.

Top module: `seqmul`

## Requirements
- R1: While reset is held and just after it is released, `prod_hi`, `prod_lo`, `cf`, `of`, `busy` and `done` are all zero.
- R2: An unsigned word operation (`size_word`=1, `is_signed`=0) returns the 32-bit product of `op_mul` and `op_mcand`. The upper 16 bits appear on `prod_hi` and the lower 16 bits on `prod_lo`.
- R3: A byte operation (`size_word`=0) uses only bits 7:0 of each operand. Bits 15:8 of the operands have no effect. The 16-bit product's upper byte appears on `prod_hi[7:0]` and its lower byte on `prod_lo[7:0]`. Bits 15:8 of both outputs are zero.
- R4: A signed operation (`is_signed`=1) treats the operands as two's complement numbers of the selected size, including the most negative value. It returns the two's-complement product, split in the same way as R2 and R3.
- R5: In unsigned mode, `cf` and `of` are both 1 when the high half of the product is nonzero. Otherwise both are 0.
- R6: In signed mode, `cf` and `of` are both 0 when the high half equals the sign extension of the low half's top bit. Otherwise both are 1.
- R7: `done` is high for exactly one cycle. It rises N+4 clock edges after the edge that samples `start`, where N is 8 for byte operations and 16 for word operations.
- R8: `busy` is high from the edge that accepts `start` until `done` rises. A `start` pulse that arrives while `busy` is high is ignored: the running result, its timing, and the absence of a second operation all remain unchanged.
- R9: `prod_hi`, `prod_lo`, `cf` and `of` change only in the cycle in which `done` rises. They hold their values until the next operation completes, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an operation when the block is idle |
| size_word | input | 1 | 1 selects word operands, 0 selects byte operands |
| is_signed | input | 1 | 1 selects two's complement arithmetic |
| op_mul | input | WORD_W | Multiplier operand |
| op_mcand | input | WORD_W | Multiplicand operand |
| prod_hi | output | WORD_W | High half of the product |
| prod_lo | output | WORD_W | Low half of the product |
| cf | output | 1 | Carry flag: high half is significant |
| of | output | 1 | Overflow flag: same rule as `cf` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default WORD_W of 16, which makes the byte size 8. These values bring all four mode combinations into reach: byte and word, each signed and unsigned. A 16×16 grid of byte operands is run in both signedness modes with junk in the upper operand bytes. The word grid covers 0, 1, all-ones, the most negative value and the 0xFFFF×0xF00F pair. Together these reach every negation path, the carry-dependent choice between one's and two's complement of the high half, and both outcomes of each flag rule. Separate scenarios check the latency for both sizes, the rejection of a `start` pulse during a busy cycle, and that the outputs hold while the inputs change.

// File: rtl/seqmul.sv
module seqmul #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              size_word,
  input  logic              is_signed,
  input  logic [WORD_W-1:0] op_mul,
  input  logic [WORD_W-1:0] op_mcand,
  output logic [WORD_W-1:0] prod_hi,
  output logic [WORD_W-1:0] prod_lo,
  output logic              cf,
  output logic              of,
  output logic              busy,
  output logic              done
);
  localparam int HALF_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(HALF_W - 1);
  localparam logic [WORD_W-1:0] MSK_BYTE = {{(WORD_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

  typedef enum logic [2:0] {S_IDLE, S_SIGN, S_INIT, S_LOOP, S_NEG, S_FIN} st_t;

  st_t               st;
  logic [WORD_W-1:0] acc_a, mul_c, mcd_b;
  logic              cy, sflag, sz_q, sg_q;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [WORD_W-1:0] fmask(input logic wd);
    return wd ? '1 : MSK_BYTE;
  endfunction

  function automatic logic ftop(input logic [WORD_W-1:0] v, input logic wd);
    return wd ? v[WORD_W-1] : v[HALF_W-1];
  endfunction

  function automatic logic [WORD_W-1:0] frrc(input logic [WORD_W-1:0] v, input logic cin,
                                             input logic wd);
    logic [WORD_W-1:0] r;
    r = (v & fmask(wd)) >> 1;
    if (wd) r[WORD_W-1] = cin;
    else    r[HALF_W-1] = cin;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] fneg(input logic [WORD_W-1:0] v, input logic wd);
    return (~v + 1'b1) & fmask(wd);
  endfunction

  logic [WORD_W-1:0] msk;
  logic [WORD_W:0]   sum_full;
  logic [WORD_W-1:0] sum_f;
  logic              add_co;
  logic [WORD_W-1:0] a_next, c_next;
  logic [WORD_W-1:0] hi_chk;
  logic              flag_v;
  logic              c_neg, b_neg;

  assign msk      = fmask(sz_q);
  assign sum_full = {1'b0, acc_a} + {1'b0, (cy ? mcd_b : '0)};
  assign sum_f    = sum_full[WORD_W-1:0] & msk;
  assign add_co   = sz_q ? sum_full[WORD_W] : sum_full[HALF_W];
  assign a_next   = frrc(sum_f, add_co, sz_q);
  assign c_next   = frrc(mul_c, sum_f[0], sz_q);
  assign c_neg    = sg_q & ftop(mul_c, sz_q);
  assign b_neg    = sg_q & ftop(mcd_b, sz_q);
  assign hi_chk   = (acc_a + {{(WORD_W-1){1'b0}}, ftop(mul_c, sz_q)}) & msk;
  assign flag_v   = sg_q ? (hi_chk != '0) : (acc_a != '0);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      acc_a   <= '0;
      mul_c   <= '0;
      mcd_b   <= '0;
      cy      <= 1'b0;
      sflag   <= 1'b0;
      sz_q    <= 1'b0;
      sg_q    <= 1'b0;
      cnt     <= '0;
      prod_hi <= '0;
      prod_lo <= '0;
      cf      <= 1'b0;
      of      <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mcd_b <= op_mcand & fmask(size_word);
          mul_c <= op_mul & fmask(size_word);
          sz_q  <= size_word;
          sg_q  <= is_signed;
          sflag <= 1'b0;
          cy    <= 1'b0;
          st    <= S_SIGN;
        end
        S_SIGN: begin
          if (c_neg) mul_c <= fneg(mul_c, sz_q);
          if (b_neg) mcd_b <= fneg(mcd_b, sz_q);
          sflag <= sflag ^ c_neg ^ b_neg;
          st    <= S_INIT;
        end
        S_INIT: begin
          acc_a <= '0;
          mul_c <= frrc(mul_c, cy, sz_q);
          cy    <= mul_c[0];
          cnt   <= sz_q ? CNT_WORD : CNT_BYTE;
          st    <= S_LOOP;
        end
        S_LOOP: begin
          acc_a <= a_next;
          mul_c <= c_next;
          cy    <= mul_c[0];
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           st  <= S_NEG;
        end
        S_NEG: begin
          if (sflag) begin
            mul_c <= fneg(mul_c, sz_q);
            acc_a <= (mul_c != '0) ? (~acc_a & msk) : fneg(acc_a, sz_q);
          end
          st <= S_FIN;
        end
        S_FIN: begin
          prod_hi <= acc_a;
          prod_lo <= mul_c;
          cf      <= flag_v;
          of      <= flag_v;
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/seqmul_chk.sv
module seqmul_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              sz_q,
  input logic              sg_q,
  input logic [WORD_W-1:0] prod_hi,
  input logic [WORD_W-1:0] prod_lo,
  input logic              cf,
  input logic              of
);
  localparam int HALF_W = WORD_W / 2;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  // R8
  idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);

  // R8
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({prod_hi, prod_lo, cf, of}));

  // R3
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sz_q) |-> (prod_hi[WORD_W-1:HALF_W] == '0 && prod_lo[WORD_W-1:HALF_W] == '0));

  // R5
  unsigned_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sg_q) |-> (cf == (prod_hi != '0)));
endmodule

bind seqmul seqmul_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sz_q(sz_q), .sg_q(sg_q), .prod_hi(prod_hi), .prod_lo(prod_lo), .cf(cf), .of(of)
);

// File: tb/seqmul_test.sv
module seqmul_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         size_word = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] op_mul = '0;
  logic [W-1:0] op_mcand = '0;
  logic [W-1:0] prod_hi, prod_lo;
  logic         cf, of, busy, done;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seqmul #(.WORD_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .size_word(size_word), .is_signed(is_signed),
    .op_mul(op_mul), .op_mcand(op_mcand), .prod_hi(prod_hi), .prod_lo(prod_lo),
    .cf(cf), .of(of), .busy(busy), .done(done)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expect_of(input logic [W-1:0] a, input logic [W-1:0] b, input logic wd,
                           input logic sg, output logic [W-1:0] hi, output logic [W-1:0] lo,
                           output logic fl);
    longint p;
    if (wd) begin
      p  = sg ? longint'($signed(a)) * longint'($signed(b)) : longint'(a) * longint'(b);
      hi = p[31:16];
      lo = p[15:0];
      fl = sg ? (p < -32768 || p > 32767) : (p > 65535);
    end else begin
      p  = sg ? longint'($signed(a[7:0])) * longint'($signed(b[7:0]))
              : longint'(a[7:0]) * longint'(b[7:0]);
      hi = {8'h00, p[15:8]};
      lo = {8'h00, p[7:0]};
      fl = sg ? (p < -128 || p > 127) : (p > 255);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic wd,
                        input logic sg, input logic poke);
    logic [W-1:0] eh, el;
    logic ef;
    int n;
    string rq;
    @(negedge clk);
    op_mul = a; op_mcand = b; size_word = wd; is_signed = sg; start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    n = 0;
    while (n < 200) begin
      if (poke && n == 3) begin
        op_mul = ~a; op_mcand = b ^ 16'h1357; size_word = ~wd; is_signed = ~sg; start = 1'b1;
      end
      @(posedge clk);
      #1;
      if (poke && n == 3) start = 1'b0;
      n++;
      if (n < (wd ? 20 : 12) && done) break;
      if (done) break;
    end
    chk("R7", "latency", n, wd ? 20 : 12);
    expect_of(a, b, wd, sg, eh, el, ef);
    rq = sg ? "R4" : (wd ? "R2" : "R3");
    chk(rq, "product", {prod_hi, prod_lo}, {eh, el});
    chk(sg ? "R6" : "R5", "cf", cf, ef);
    chk(sg ? "R6" : "R5", "of", of, ef);
    @(posedge clk);
    #1 chk("R7", "done width", done, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "outputs in reset", {prod_hi, prod_lo, cf, of, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "outputs after reset", {prod_hi, prod_lo, cf, of, busy, done}, 0);
  endtask

  task automatic t_byte_grid(input logic sg);
    logic [7:0] v [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h7F, 8'h80, 8'h81, 8'hFF,
                           8'h55, 8'hAA, 8'h0F, 8'hF0, 8'h40, 8'hC0, 8'h7E, 8'hFE};
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        run_op({8'hA5, v[i]}, {8'h3C ^ 8'(j), v[j]}, 1'b0, sg, 1'b0);
  endtask

  task automatic t_word_grid(input logic sg);
    logic [15:0] v [10] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF,
                            16'hF00F, 16'h1234, 16'h8001, 16'h00FF, 16'hFF00};
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        run_op(v[i], v[j], 1'b1, sg, 1'b0);
  endtask

  task automatic t_ignore_start;
    // R8: start during busy with other operands must not disturb the result
    run_op(16'hFFFF, 16'hF00F, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8", "no second operation", busy, 0);
    run_op(16'h0080, 16'h0080, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    chk("R8", "no second operation", busy, 0);
  endtask

  task automatic t_hold;
    logic [2*W+1:0] snap;
    run_op(16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0);
    snap = {prod_hi, prod_lo, cf, of};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      op_mul = 16'(k * 911); op_mcand = ~op_mul; size_word = k[0]; is_signed = k[1];
    end
    @(negedge clk);
    chk("R9", "outputs held", {prod_hi, prod_lo, cf, of}, snap);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_byte_grid(1'b0);
    t_byte_grid(1'b1);
    t_word_grid(1'b0);
    t_word_grid(1'b1);
    t_ignore_start();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule